// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Control Core

This block is the digital half of an 8-bit successive-approximation converter that is reached through a synchronous serial slave port. The host lowers an active-low select line and clocks a bit stream into the serial input on rising edges. The block skips any leading zeros and treats the first 1 as a start marker. It then collects a channel address word of `ADDR_W` bits and presents that word to the analog switch matrix.

Half a clock after the address is complete, the serial output leaves high impedance, drives one zero, and raises the busy flag. The core then runs one trial per clock. The trial code goes to an external DAC, and an external comparator answers on `cmp_above`. Each decision is placed on the serial output on the falling edge at which it is made. When all eight decisions are done, busy drops. The result then goes out a second time in reverse bit order. The lowest bit is shared by the two streams, so the reversed stream begins at bit 1.

A hold input can park the output on the lowest bit until the host releases it. After the reversed stream the output is driven low. Raising the select line ends or aborts the transaction at any point.

Top module: `sar_serial_core`

## Requirements
- R1: While reset is asserted and afterwards with select high, `sdo_oe` is 0, `busy` is 0, `trial_code` is 0x00 and `mux_addr` is 0.
- R2: With select low, input bits are taken on rising edges. Leading zeros are skipped, and the first 1 is the start marker. The next `ADDR_W` bits, most significant first, appear on `mux_addr` right after the rising edge that takes the last of them.
- R3: On the falling edge after the last address bit, `sdo_oe` goes to 1 with `sdo` = 0 and `busy` goes to 1.
- R4: One rising edge after the address is complete, `trial_code` is 0x80. During step k (7 down to 0), it holds the bits already decided above k, with bit k set and all lower bits clear. Outside a conversion it is 0x00.
- R5: From the end of the address until select rises, the serial input has no effect: `mux_addr` and the result bits do not change whatever it carries.
- R6: On each of the 8 falling edges after the leading zero, `sdo` carries the comparator decision for the current bit, MSB first. A 1 keeps the bit and a 0 clears it, so an input below zero gives 0x00 and an input at or above full scale gives 0xFF.
- R7: On the falling edge after the eighth decision, `busy` is 0 and `trial_code` is 0x00.
- R8: With `shift_hold` low when the conversion ends, bits 1 through 7 follow on the next seven falling edges, one bit per edge.
- R9: With `shift_hold` high when the conversion ends, `sdo` keeps showing bit 0 until a rising edge samples `shift_hold` low. Bits 1 through 7 then follow on the next falling edges.
- R10: After bit 7 of the reversed stream, `sdo` is driven 0 with `sdo_oe` 1 until select rises.
- R11: Select going high drops `sdo_oe` at once. After the next rising edge and falling edge, `busy`, `trial_code` and `mux_addr` are all 0, and a new transaction behaves normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; inputs sampled on rising edges, output updated on falling edges |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select |
| di | input | 1 | Serial input carrying start marker and channel address |
| shift_hold | input | 1 | High parks the output on bit 0 before the reversed stream |
| cmp_above | input | 1 | Comparator answer: 1 when the analog input is at or above the trial level |
| sdo | output | 1 | Serial output data |
| sdo_oe | output | 1 | Output enable for the serial output driver (0 = high impedance) |
| busy | output | 1 | High while the settling step and the eight trials run |
| mux_addr | output | ADDR_W | Selected channel address |
| trial_code | output | 8 | Trial code sent to the external DAC |

## Verification
The in-line assertions watch properties that must hold on every edge. The channel address stays frozen while busy is high, and a nonzero trial code is only seen while busy. Busy only rises out of the settling step, and a raised select clears busy, the output enable and the trial code by the next rising edge. The tail of the output stays low. The bench scenarios are what show the stream contents. They check the exact bit order, that the shared bit is sent once, how long the hold lasts, that leading zeros are skipped, and that results clamp at both ends. Each of these is compared against an analog value that the bench models through the comparator input.

// File: rtl/sar_serial_pkg.sv
// Package: sequencer state shared by the serial converter core modules.
package sar_serial_pkg;

    // Transaction phases, advanced on rising edges of the serial clock.
    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,  // select low, looking for the start marker
        ST_ADDR   = 3'd1,  // collecting channel address bits
        ST_SETTLE = 3'd2,  // one clock for the analog switches to settle
        ST_CONV   = 3'd3,  // successive-approximation trials
        ST_HOLD   = 3'd4,  // output parked on bit 0 while hold is high
        ST_SHIFT  = 3'd5,  // reversed-order stream, bits 1 upward
        ST_TAIL   = 3'd6   // output driven low until select rises
    } seq_state_t;

endpackage

// File: rtl/sar_seq.sv
// Module: sar_seq
// Rising-edge sequencer. It finds the start marker, collects the channel
// address, and walks the trial and output bit index.
// Assumes: cs_n high clears the whole transaction at the next rising edge;
// ADDR_W lies between 2 and 4.
module sar_seq
    import sar_serial_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int RES_W  = 8,
    parameter bit HAS_SE = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       di,
    input  logic                       shift_hold,
    input  logic                       busy,
    output seq_state_t                 state,
    output logic [$clog2(RES_W)-1:0]   idx,
    output logic [ADDR_W-1:0]          mux_addr
);
    localparam int IDX_W  = $clog2(RES_W);
    localparam int ACNT_W = (ADDR_W > 2) ? $clog2(ADDR_W) : 1;
    localparam logic [IDX_W-1:0]  IDX_TOP  = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0]  IDX_ONE  = IDX_W'(1);
    localparam logic [ACNT_W-1:0] ACNT_END = ACNT_W'(ADDR_W - 1);

    logic              hold_en;
    logic [ACNT_W-1:0] acnt;

    // Select the hold behaviour: wired to the pin or tied off.
    generate
        if (HAS_SE) begin : g_hold_pin
            assign hold_en = shift_hold;
        end else begin : g_hold_none
            assign hold_en = 1'b0;
        end
    endgenerate

    // Advance the transaction phase, the address shifter and the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n) begin
            state    <= ST_WAIT;
            idx      <= '0;
            acnt     <= '0;
            mux_addr <= '0;
        end else begin
            case (state)
                ST_WAIT: begin
                    if (di) begin
                        state    <= ST_ADDR;
                        acnt     <= '0;
                        mux_addr <= '0;
                    end
                end
                ST_ADDR: begin
                    mux_addr <= {mux_addr[ADDR_W-2:0], di};
                    acnt     <= acnt + ACNT_W'(1);
                    if (acnt == ACNT_END) begin
                        state <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    state <= ST_CONV;
                    idx   <= IDX_TOP;
                end
                ST_CONV: begin
                    if (idx == '0) begin
                        state <= hold_en ? ST_HOLD : ST_SHIFT;
                        idx   <= IDX_ONE;
                    end else begin
                        idx <= idx - IDX_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (!hold_en) begin
                        state <= ST_SHIFT;
                        idx   <= IDX_ONE;
                    end
                end
                ST_SHIFT: begin
                    if (idx == IDX_TOP) begin
                        state <= ST_TAIL;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                default: begin
                    state <= ST_TAIL;
                end
            endcase
        end
    end

    // The address must not move while a conversion runs.
    AST_ADDR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n || cs_n)
        busy |=> $stable(mux_addr)); // R5

endmodule

// File: rtl/sar_result.sv
// Module: sar_result
// Keeps the decided result bits, written on falling edges from the
// comparator, and forms the trial code for the DAC.
// Assumes: the comparator answer is settled by the falling edge that
// follows the rising edge that applied the trial code.
module sar_result
    import sar_serial_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  seq_state_t                 state,
    input  logic [$clog2(RES_W)-1:0]   idx,
    input  logic                       cmp_above,
    output logic [RES_W-1:0]           result,
    output logic [RES_W-1:0]           trial_code
);
    localparam int IDX_W = $clog2(RES_W);

    logic in_conv;
    assign in_conv = (state == ST_CONV);

    // Record each decision; clear the result outside a transaction.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_conv) begin
            result[idx] <= cmp_above;
        end else if (state == ST_WAIT || state == ST_ADDR || state == ST_SETTLE) begin
            result <= '0;
        end
    end

    // Trial bit i: decided value above the index, set at it, clear below.
    generate
        for (genvar i = 0; i < RES_W; i++) begin : g_trial
            assign trial_code[i] = in_conv &&
                ((IDX_W'(i) > idx) ? result[i] : (IDX_W'(i) == idx));
        end
    endgenerate

endmodule

// File: rtl/sar_dout.sv
// Module: sar_dout
// Falling-edge output stage. It drives the serial data, its enable and
// the busy flag from the phase the sequencer is in.
// Assumes: the sequencer phase changes only on rising edges.
module sar_dout
    import sar_serial_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  seq_state_t                 state,
    input  logic [$clog2(RES_W)-1:0]   idx,
    input  logic                       cmp_above,
    input  logic [RES_W-1:0]           result,
    output logic                       do_q,
    output logic                       oe_q,
    output logic                       busy_q
);

    // Choose the output bit, enable and busy for the coming half cycle.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            do_q   <= 1'b0;
            oe_q   <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            case (state)
                ST_SETTLE: begin
                    do_q   <= 1'b0;
                    oe_q   <= 1'b1;
                    busy_q <= 1'b1;
                end
                ST_CONV: begin
                    do_q   <= cmp_above;
                    oe_q   <= 1'b1;
                    busy_q <= 1'b1;
                end
                ST_HOLD: begin
                    do_q   <= result[0];
                    oe_q   <= 1'b1;
                    busy_q <= 1'b0;
                end
                ST_SHIFT: begin
                    do_q   <= result[idx];
                    oe_q   <= 1'b1;
                    busy_q <= 1'b0;
                end
                ST_TAIL: begin
                    do_q   <= 1'b0;
                    oe_q   <= 1'b1;
                    busy_q <= 1'b0;
                end
                default: begin
                    do_q   <= 1'b0;
                    oe_q   <= 1'b0;
                    busy_q <= 1'b0;
                end
            endcase
        end
    end

    // Once in the tail phase, the output must read low.
    AST_TAIL_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TAIL && oe_q) |-> !do_q); // R10

endmodule

// File: rtl/sar_serial_core.sv
// Module: sar_serial_core (top)
// Serial-port successive-approximation converter control: start and
// address capture, eight trials against an external comparator, and the
// two-order result stream on a tri-stateable output.
// Assumes: the DAC and comparator settle within half a serial clock.
module sar_serial_core
    import sar_serial_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter bit HAS_SE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              di,
    input  logic              shift_hold,
    input  logic              cmp_above,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              busy,
    output logic [ADDR_W-1:0] mux_addr,
    output logic [7:0]        trial_code
);
    localparam int RES_W = 8;
    localparam int IDX_W = $clog2(RES_W);

    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [RES_W-1:0]  result;
    logic              oe_q;

    sar_seq #(.ADDR_W(ADDR_W), .RES_W(RES_W), .HAS_SE(HAS_SE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .di         (di),
        .shift_hold (shift_hold),
        .busy       (busy),
        .state      (state),
        .idx        (idx),
        .mux_addr   (mux_addr)
    );

    sar_result #(.RES_W(RES_W)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .idx        (idx),
        .cmp_above  (cmp_above),
        .result     (result),
        .trial_code (trial_code)
    );

    sar_dout #(.RES_W(RES_W)) u_dout (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .idx        (idx),
        .cmp_above  (cmp_above),
        .result     (result),
        .do_q       (sdo),
        .oe_q       (oe_q),
        .busy_q     (busy)
    );

    // Release the output at once when the select line rises.
    assign sdo_oe = oe_q & ~cs_n;

    AST_TRIAL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_code != 8'h00) |-> busy); // R4

    AST_BUSY_RISES_FROM_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (state == ST_SETTLE)); // R3

    AST_SELECT_HIGH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!busy && !oe_q && trial_code == 8'h00)); // R11

endmodule

// File: tb/tb_sar_serial_core.sv
`timescale 1ns/1ps
module tb_sar_serial_core;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              di = 1'b0;
    logic              shift_hold = 1'b0;
    logic              cmp_above;
    logic              sdo;
    logic              sdo_oe;
    logic              busy;
    logic [ADDR_W-1:0] mux_addr;
    logic [7:0]        trial_code;

    int vin_model = 0;
    int n_checks  = 0;
    int n_fail    = 0;
    bit done      = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // Comparator model: 1 when the analog value is at or above the trial.
    assign cmp_above = (vin_model >= int'(trial_code));

    sar_serial_core #(.ADDR_W(ADDR_W), .HAS_SE(1'b1)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .di         (di),
        .shift_hold (shift_hold),
        .cmp_above  (cmp_above),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .busy       (busy),
        .mux_addr   (mux_addr),
        .trial_code (trial_code)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] expected_code(input int v);
        if (v < 0)   return 8'h00;
        if (v > 255) return 8'hFF;
        return v[7:0];
    endfunction

    // Present one input bit; returns just after the rising edge that takes it.
    task automatic send_bit(input logic b);
        di = b;
        @(posedge clk); #5;
    endtask

    // Select, leading zeros, start marker and address; checks R2.
    task automatic open_txn(input int lead, input logic [ADDR_W-1:0] addr);
        cs_n = 1'b0;
        for (int i = 0; i < lead; i++) send_bit(1'b0);
        check(busy == 1'b0 && sdo_oe == 1'b0, "R2 no start before marker", {busy, sdo_oe}, 0);
        send_bit(1'b1);
        for (int b = ADDR_W - 1; b >= 0; b--) send_bit(addr[b]);
        check(mux_addr == addr, "R2 address capture", mux_addr, addr);
    endtask

    // Release select and check the cleared state; checks R11.
    task automatic close_txn();
        @(posedge clk); #5;
        cs_n = 1'b1;
        di   = 1'b0;
        #1;
        check(sdo_oe == 1'b0, "R11 output released at once", sdo_oe, 0);
        @(posedge clk); #2;
        check(mux_addr == '0 && trial_code == 8'h00, "R11 cleared after edge", {mux_addr, trial_code}, 0);
        @(negedge clk); #5;
        check(busy == 1'b0, "R11 busy cleared", busy, 0);
        shift_hold = 1'b0;
    endtask

    // Full conversion scenario with optional hold of bit 0.
    task automatic conversion(input int lead, input logic [ADDR_W-1:0] addr,
                              input int vin, input int hold_edges);
        logic [7:0] exp;
        logic [7:0] exp_trial;
        exp = expected_code(vin);
        vin_model = vin;
        shift_hold = (hold_edges > 0);
        open_txn(lead, addr);
        @(negedge clk); #5;
        check(sdo_oe == 1'b1 && sdo == 1'b0, "R3 leading zero driven", {sdo_oe, sdo}, 2);
        check(busy == 1'b1, "R3 busy after settling", busy, 1);
        @(posedge clk); #5;
        check(trial_code == 8'h80, "R4 first trial", trial_code, 8'h80);
        di = 1'b1;   // noise on the input during conversion
        for (int k = 7; k >= 0; k--) begin
            @(negedge clk); #5;
            exp_trial = ((exp >> (k + 1)) << (k + 1)) | (8'h01 << k);
            check(trial_code == exp_trial, "R4 trial during step", trial_code, exp_trial);
            check(sdo == exp[k], "R6 decision bit MSB first", sdo, exp[k]);
            di = ~di;   // R5: must not disturb anything
        end
        @(negedge clk); #5;
        check(busy == 1'b0 && trial_code == 8'h00, "R7 conversion end", {busy, trial_code}, 0);
        if (hold_edges > 0) begin
            check(sdo == exp[0], "R9 bit 0 held", sdo, exp[0]);
            for (int h = 1; h < hold_edges; h++) begin
                @(negedge clk); #5;
                check(sdo == exp[0], "R9 bit 0 still held", sdo, exp[0]);
            end
            shift_hold = 1'b0;
            for (int k = 1; k < 8; k++) begin
                @(negedge clk); #5;
                check(sdo == exp[k], "R9 reversed stream after hold", sdo, exp[k]);
            end
        end else begin
            check(sdo == exp[1], "R8 reversed stream starts at bit 1", sdo, exp[1]);
            for (int k = 2; k < 8; k++) begin
                @(negedge clk); #5;
                check(sdo == exp[k], "R8 reversed stream bit", sdo, exp[k]);
            end
        end
        for (int t = 0; t < 3; t++) begin
            @(negedge clk); #5;
            check(sdo == 1'b0 && sdo_oe == 1'b1, "R10 tail low", {sdo_oe, sdo}, 2);
        end
        check(mux_addr == addr, "R5 address unchanged by input", mux_addr, addr);
        close_txn();
    endtask

    // Select rises in the middle of the trials.
    task automatic abort_midway();
        vin_model = 8'h77;
        open_txn(1, 4'h6);
        repeat (3) begin @(negedge clk); #5; end
        check(busy == 1'b1, "R11 busy before abort", busy, 1);
        close_txn();
    endtask

    task automatic reset_state();
        repeat (4) @(posedge clk);
        #5;
        check(sdo_oe == 1'b0 && busy == 1'b0, "R1 reset outputs", {sdo_oe, busy}, 0);
        check(trial_code == 8'h00 && mux_addr == '0, "R1 reset codes", {mux_addr, trial_code}, 0);
        rst_n = 1'b1;
        @(posedge clk); #5;
        @(negedge clk); #5;
        check(sdo_oe == 1'b0 && busy == 1'b0, "R1 idle with select high", {sdo_oe, busy}, 0);
    endtask

    initial begin
        reset_state();
        conversion(3, 4'b1011, 8'hA5, 0);
        conversion(0, 4'b0000, 8'h3C, 3);
        conversion(2, 4'b1111, -20, 0);    // R6 below zero gives 0x00
        conversion(1, 4'b0101, 300, 0);    // R6 above full scale gives 0xFF
        conversion(5, 4'b1000, 8'h01, 1);
        abort_midway();
        conversion(0, 4'b0011, 8'h5A, 0);  // R11 new transaction after abort
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule